// File: doc/BRIEF.md
# Two-Wire Conversion Frame Receiver

This block sits on the host side of a two-wire, output-only serial link. On that link a data converter drives both the clock line and the data line, and there is no select line. The receiver samples both lines with its own system clock through two-flop synchronizers. It waits while both lines are high, which means a conversion is in progress. It treats a simultaneous drop of both lines as the start of a result frame.

Once a frame has started, the receiver captures the data line on every rising edge of the link clock, most significant bit first, until it holds 24 bits. The first bit captured is the end-of-conversion flag and must be 0. A complete frame is presented as a 24-bit word together with a one-cycle valid strobe. A frame that starts with a 1, or a link clock that stays high for too long in the middle of a frame, raises a one-cycle framing-error flag. In both cases the receiver returns to waiting for the next frame announcement. Splitting the word into result fields is left to downstream logic.

Top module: `eoc_frame_rx`

## Requirements
- R1: While reset is high and in the first cycle after it, `word_o` is all zeros and `valid_o` and `frame_err_o` are low.
- R2: A frame starts only when the synchronized sample pair goes from both high to both low between two consecutive clock samples. A drop of one line alone, or a drop from any other state, starts no frame, and later link clock edges then produce neither a valid nor an error.
- R3: During a frame the data line is captured on each synchronized rising edge of the link clock and shifted in MSB first. After 24 captures the first captured bit sits in `word_o[23]` and reads 0.
- R4: `valid_o` is high for exactly one clock per completed frame. It rises on the third rising clock edge after the port-level link clock rise that carries the 24th bit, and `word_o` takes the new word in that same cycle and keeps it until the next completed frame.
- R5: If the first captured bit is 1, `frame_err_o` pulses for one clock, no valid is produced, `word_o` is unchanged and the receiver returns to waiting for a frame start.
- R6: If the synchronized link clock stays high for more than TIMEOUT consecutive clocks (default 64) in the middle of a frame, `frame_err_o` pulses for one clock and the receiver abandons the frame without changing `word_o`.
- R7: After a completed frame or a framing error, the next pair of lines that go both high and then both low together starts a new frame that is received normally.
- R8: `valid_o` and `frame_err_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the link |
| rst | input | 1 | Synchronous active-high reset |
| sck_in | input | 1 | Link serial clock, driven by the converter |
| sdo_in | input | 1 | Link serial data, driven by the converter |
| word_o | output | 24 | Last completed frame, MSB first |
| valid_o | output | 1 | One-cycle strobe when `word_o` is updated |
| frame_err_o | output | 1 | One-cycle strobe on a bad start bit or a mid-frame clock timeout |

## Verification
The hardest situation to reach is the mid-frame timeout. It needs a frame that has started correctly and has already captured some bits, after which the link clock freezes high for longer than the timeout window. The stimulus starts a legal frame, sends five bits, and then holds the clock line high for well over TIMEOUT cycles. It then checks that a normal frame is still accepted. A bad start bit is produced separately by forcing the first data bit to 1. Single-line drops are produced by lowering the two lines in separate cycles and then pulsing the clock.

// File: rtl/frx_pkg.sv
package frx_pkg;
  typedef enum logic [0:0] {
    ST_WAIT  = 1'b0,
    ST_FRAME = 1'b1
  } frx_state_e;

  localparam logic [1:0] LINES_HIGH = 2'b11;
  localparam logic [1:0] LINES_LOW  = 2'b00;
endpackage

// File: rtl/frx_sync.sv
module frx_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[0] <= '0;
          else     pipe[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[g] <= '0;
          else     pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/frx_shift.sv
module frx_shift #(
  parameter int BITS = 24,
  parameter int CW   = $clog2(BITS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            shift_en,
  input  logic            bit_in,
  output logic [BITS-1:0] data,
  output logic [CW-1:0]   count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data  <= '0;
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (shift_en) begin
      data  <= {data[BITS-2:0], bit_in};
      count <= count + 1'b1;
    end
  end

  // R3: a frame never holds more than BITS captured bits
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(BITS));
endmodule

// File: rtl/eoc_frame_rx.sv
module eoc_frame_rx
  import frx_pkg::*;
#(
  parameter int FRAME_BITS = 24,
  parameter int TIMEOUT    = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sck_in,
  input  logic                  sdo_in,
  output logic [FRAME_BITS-1:0] word_o,
  output logic                  valid_o,
  output logic                  frame_err_o
);
  localparam int CW  = $clog2(FRAME_BITS + 1);
  localparam int TOW = $clog2(TIMEOUT + 1);

  logic [1:0] lines_now, lines_prev;
  logic       rise, start_seen, first_bit, last_bit, bad_start;
  frx_state_e state;
  logic [TOW-1:0] hi_cnt;
  logic [FRAME_BITS-1:0] sh_data;
  logic [CW-1:0]         sh_count;

  frx_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sck_in, sdo_in}),
    .q   (lines_now)
  );

  always_ff @(posedge clk) begin
    if (rst) lines_prev <= '0;
    else     lines_prev <= lines_now;
  end

  assign rise       = lines_now[1] & ~lines_prev[1];
  assign start_seen = (lines_prev == LINES_HIGH) && (lines_now == LINES_LOW);
  assign first_bit  = (sh_count == '0);
  assign last_bit   = (sh_count == CW'(FRAME_BITS - 1));
  assign bad_start  = first_bit && lines_now[0];

  frx_shift #(.BITS(FRAME_BITS), .CW(CW)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .clr      (state == ST_WAIT),
    .shift_en ((state == ST_FRAME) && rise && !bad_start),
    .bit_in   (lines_now[0]),
    .data     (sh_data),
    .count    (sh_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_WAIT;
      hi_cnt      <= '0;
      word_o      <= '0;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
      unique case (state)
        ST_WAIT: begin
          if (start_seen) begin
            state  <= ST_FRAME;
            hi_cnt <= '0;
          end
        end
        ST_FRAME: begin
          if (rise) begin
            hi_cnt <= TOW'(1);
            if (bad_start) begin
              frame_err_o <= 1'b1;
              state       <= ST_WAIT;
            end else if (last_bit) begin
              word_o  <= {sh_data[FRAME_BITS-2:0], lines_now[0]};
              valid_o <= 1'b1;
              state   <= ST_WAIT;
            end
          end else if (!lines_now[1]) begin
            hi_cnt <= '0;
          end else if (hi_cnt == TOW'(TIMEOUT)) begin
            frame_err_o <= 1'b1;
            state       <= ST_WAIT;
          end else begin
            hi_cnt <= hi_cnt + 1'b1;
          end
        end
        default: state <= ST_WAIT;
      endcase
    end
  end

  // R8: the two strobes exclude each other
  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(valid_o && frame_err_o));
  // R4: valid is a single-cycle pulse
  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  // R5: error flag is a single-cycle pulse
  assert_err_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |=> !frame_err_o);
  // R3: a delivered word carries a zero end-of-conversion bit on top
  assert_eoc_zero_R3: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> !word_o[FRAME_BITS-1]);
  // R2: without a joint drop the receiver keeps waiting
  assert_wait_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !start_seen) |=> (state == ST_WAIT));
  // R5/R6: word is left alone when a frame is rejected
  assert_word_kept_R5: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |-> $stable(word_o));
endmodule

// File: tb/eoc_frame_rx_tb.sv
module eoc_frame_rx_tb;
  localparam int BITS = 24;
  localparam int TMO  = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck_in = 1'b1;
  logic sdo_in = 1'b1;
  logic [BITS-1:0] word_o;
  logic valid_o, frame_err_o;

  always #5 clk = ~clk;

  eoc_frame_rx #(.FRAME_BITS(BITS), .TIMEOUT(TMO)) u_dut (
    .clk(clk), .rst(rst), .sck_in(sck_in), .sdo_in(sdo_in),
    .word_o(word_o), .valid_o(valid_o), .frame_err_o(frame_err_o)
  );

  int checks = 0, errors = 0, n_valid = 0, n_err = 0, n_both = 0;

  // behavioural reference model
  bit [1:0] m_p1, m_p2, m_pq;
  bit m_act, m_rise;
  int m_n, m_hi;
  bit [BITS-1:0] m_sh, e_word;
  bit e_valid, e_err;

  always @(posedge clk) begin
    if (rst) begin
      m_p1 = 0; m_p2 = 0; m_pq = 0; m_act = 0; m_n = 0; m_hi = 0;
      m_sh = 0; e_word = 0; e_valid = 0; e_err = 0;
    end else begin
      e_valid = 0; e_err = 0;
      m_rise = m_p2[1] && !m_pq[1];
      if (!m_act) begin
        if (m_pq == 2'b11 && m_p2 == 2'b00) begin m_act = 1; m_n = 0; m_hi = 0; end
      end else if (m_rise) begin
        m_hi = 1;
        if (m_n == 0 && m_p2[0]) begin e_err = 1; m_act = 0; end
        else begin
          m_sh = {m_sh[BITS-2:0], m_p2[0]};
          m_n++;
          if (m_n == BITS) begin e_valid = 1; e_word = m_sh; m_act = 0; end
        end
      end else if (!m_p2[1]) m_hi = 0;
      else if (m_hi == TMO) begin e_err = 1; m_act = 0; end
      else m_hi++;
      m_pq = m_p2; m_p2 = m_p1; m_p1 = {sck_in, sdo_in};
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (valid_o !== e_valid || frame_err_o !== e_err || word_o !== e_word) begin
        errors++;
        $display("FAIL R4/R5/R6 cycle compare: act v=%0b e=%0b w=%h exp v=%0b e=%0b w=%h",
                 valid_o, frame_err_o, word_o, e_valid, e_err, e_word);
      end
      if (valid_o) n_valid++;
      if (frame_err_o) n_err++;
      if (valid_o && frame_err_o) n_both++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hold_idle(input int n);
    sck_in = 1'b1; sdo_in = 1'b1;
    wait_n(n);
  endtask

  task automatic send(input logic [BITS-1:0] w, input bit bad, input int nbits);
    hold_idle(8);
    sck_in = 1'b0; sdo_in = 1'b0;
    wait_n(4);
    for (int i = BITS - 1; i >= BITS - nbits; i--) begin
      sck_in = 1'b0;
      sdo_in = (i == BITS - 1 && bad) ? 1'b1 : w[i];
      wait_n(4);
      sck_in = 1'b1;
      wait_n(4);
    end
    sdo_in = 1'b1;
    wait_n(8);
  endtask

  initial begin
    wait_n(4);
    // R1 reset state
    chk(word_o == 0, "R1 word", word_o, 0);
    chk(!valid_o && !frame_err_o, "R1 strobes", {valid_o, frame_err_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(word_o == 0 && !valid_o && !frame_err_o, "R1 after release", word_o, 0);
    hold_idle(10);

    send(24'h5A3C1E, 0, BITS);
    chk(n_valid == 1, "R4 one valid", n_valid, 1);
    chk(word_o == 24'h5A3C1E, "R3 word", word_o, 24'h5A3C1E);
    chk(word_o[23] == 1'b0, "R3 eoc bit", word_o[23], 0);

    send(24'h7FFFFF, 0, BITS);
    send(24'h000001, 0, BITS);
    chk(n_valid == 3, "R4 valid count", n_valid, 3);
    chk(word_o == 24'h000001, "R3 word lsb", word_o, 24'h000001);

    // R2 single-line drops: clock alone, then data alone then clock
    hold_idle(8);
    sck_in = 1'b0; wait_n(6);
    for (int k = 0; k < 24; k++) begin sck_in = 1'b1; wait_n(4); sck_in = 1'b0; wait_n(4); end
    hold_idle(8);
    sdo_in = 1'b0; wait_n(6);
    sck_in = 1'b0; wait_n(6);
    for (int k = 0; k < 24; k++) begin sck_in = 1'b1; wait_n(4); sck_in = 1'b0; wait_n(4); end
    hold_idle(8);
    chk(n_valid == 3 && n_err == 0, "R2 no frame", n_valid, 3);
    chk(word_o == 24'h000001, "R2 word kept", word_o, 24'h000001);

    // R5 bad start bit
    send(24'h123456, 1, 1);
    chk(n_err == 1, "R5 error pulse", n_err, 1);
    chk(n_valid == 3 && word_o == 24'h000001, "R5 word kept", word_o, 24'h000001);

    // R6 mid-frame timeout
    send(24'h2468AC, 0, 5);
    sck_in = 1'b1; sdo_in = 1'b0;
    wait_n(TMO + 40);
    sdo_in = 1'b1;
    wait_n(8);
    chk(n_err == 2, "R6 timeout error", n_err, 2);
    chk(word_o == 24'h000001, "R6 word kept", word_o, 24'h000001);

    // R7 recovery
    send(24'h00ABCD, 0, BITS);
    chk(n_valid == 4, "R7 valid after error", n_valid, 4);
    chk(word_o == 24'h00ABCD, "R7 word", word_o, 24'h00ABCD);
    chk(n_both == 0, "R8 exclusive strobes", n_both, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule